// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is a parameterised integer adder/subtractor, 32 bits wide by default. It performs four operations: plain add, add with carry, plain subtract, and subtract with carry. The carry-in comes from an external flag input. The result is combinational from the operands. Four condition flags are held in a register: negative, zero, carry and overflow. That register loads the freshly computed flags on a clock edge where the set-flags enable is high. Otherwise it keeps its contents.

Subtraction uses the inverted-borrow carry convention, so a carry of 1 means no borrow occurred. The with-carry variants use the incoming carry in two places. It is added into the arithmetic, and it also decides the carry-out when the compared values are equal. The unit is intended to sit in an integer execute stage beside a separate logic unit and shifter. Neither of those is part of this block.

Top module: `addsub_flags_alu`

## Requirements
- R1: `result` is combinational and depends on `op_sel`. Code 0 gives A+B. Code 1 gives A+B+carry_in. Code 2 gives A−B. Code 3 gives A−B−(1−carry_in). All results are taken modulo 2^WIDTH.
- R2: `flags[3]` (negative) takes the most significant bit of `result` on a clock edge where `set_flags` is high.
- R3: `flags[2]` (zero) is set on such an edge exactly when `result` is all zeros.
- R4: For code 0, `flags[1]` (carry) is loaded with 1 exactly when `result` is unsigned-less than A.
- R5: For code 1, carry is loaded with 1 when `result` is unsigned-less than A, or when `result` equals A and `carry_in` is 1.
- R6: For code 2, carry is loaded with 1 exactly when A is unsigned-greater-or-equal to B.
- R7: For code 3, carry is loaded with 1 when A is unsigned-greater than B, or when A equals B and `carry_in` is 1.
- R8: For codes 0 and 1, `flags[0]` (overflow) is loaded with the top bit of (result XOR A) AND NOT (A XOR B).
- R9: For codes 2 and 3, overflow is loaded with the top bit of (result XOR A) AND (A XOR B).
- R10: On a clock edge where `set_flags` is low, all four flag bits keep their previous values.
- R11: While `rst_n` is low, `flags` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| op_sel | input | 2 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with carry) |
| carry_in | input | 1 | Incoming carry flag |
| set_flags | input | 1 | Load the flag register on this edge |
| result | output | WIDTH | Arithmetic result |
| flags | output | 4 | Registered flags: bit 3 negative, bit 2 zero, bit 1 carry, bit 0 overflow |

## Verification
The only internal state is the four-bit flag register. A wrong carry or overflow value shows up on `flags` one clock edge after the operation that set it. A failure to hold the flags shows up on the first edge where `set_flags` is low. The bench therefore samples `flags` half a cycle after each edge and compares it with a 33-bit reference sum. The result path has no state, so it is checked in the same cycle the operands are applied. The operands include the corner values zero, largest positive, smallest negative and all ones. Equal-operand cases are included so that the carry tie-break on `carry_in` is exercised.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_SUB  = 2'd2,
    OP_SUBC = 2'd3
  } arith_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } cond_flags_t;

  function automatic logic op_is_sub(input arith_op_e op);
    return (op == OP_SUB) || (op == OP_SUBC);
  endfunction

  function automatic logic op_uses_cin(input arith_op_e op);
    return (op == OP_ADDC) || (op == OP_SUBC);
  endfunction

endpackage

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  arith_op_e        op,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] b_eff;
  logic             cin_eff;

  always_comb begin
    b_eff = op_is_sub(op) ? ~op_b : op_b;
    if (op_uses_cin(op)) begin
      cin_eff = carry_in;
    end else begin
      cin_eff = op_is_sub(op);
    end
    sum = op_a + b_eff + {{(WIDTH-1){1'b0}}, cin_eff};
  end

endmodule

// File: rtl/addsub_flag_logic.sv
module addsub_flag_logic
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] sum,
  input  arith_op_e        op,
  input  logic             carry_in,
  output cond_flags_t      flags_nxt
);

  localparam int MSB = WIDTH - 1;

  logic             sum_below_a;
  logic             sum_eq_a;
  logic             a_above_b;
  logic             a_eq_b;
  logic [WIDTH-1:0] sign_mix;

  always_comb begin
    sum_below_a = (sum < op_a);
    sum_eq_a    = (sum == op_a);
    a_above_b   = (op_a > op_b);
    a_eq_b      = (op_a == op_b);

    flags_nxt.neg  = sum[MSB];
    flags_nxt.zero = ~|sum;

    unique case (op)
      OP_ADD:  flags_nxt.carry = sum_below_a;
      OP_ADDC: flags_nxt.carry = sum_below_a | (sum_eq_a & carry_in);
      OP_SUB:  flags_nxt.carry = a_above_b | a_eq_b;
      default: flags_nxt.carry = a_above_b | (a_eq_b & carry_in);
    endcase

    if (op_is_sub(op)) begin
      sign_mix = (sum ^ op_a) & (op_a ^ op_b);
    end else begin
      sign_mix = (sum ^ op_a) & ~(op_a ^ op_b);
    end
    flags_nxt.ovf = sign_mix[MSB];
  end

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
  import addsub_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  cond_flags_t flags_nxt,
  output cond_flags_t flags_q
);

  cond_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load_en) begin
      flags_d = flags_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/addsub_flags_alu.sv
module addsub_flags_alu
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       op_sel,
  input  logic             carry_in,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);

  arith_op_e   op;
  cond_flags_t flags_nxt;
  cond_flags_t flags_q;

  assign op = arith_op_e'(op_sel);

  addsub_datapath #(.WIDTH(WIDTH)) u_datapath (
    .op_a     (op_a),
    .op_b     (op_b),
    .op       (op),
    .carry_in (carry_in),
    .sum      (result)
  );

  addsub_flag_logic #(.WIDTH(WIDTH)) u_flag_logic (
    .op_a      (op_a),
    .op_b      (op_b),
    .sum       (result),
    .op        (op),
    .carry_in  (carry_in),
    .flags_nxt (flags_nxt)
  );

  addsub_flag_reg u_flag_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (set_flags),
    .flags_nxt (flags_nxt),
    .flags_q   (flags_q)
  );

  assign flags = flags_q;

endmodule

// File: rtl/addsub_flags_alu_chk.sv
module addsub_flags_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       op_sel,
  input logic             carry_in,
  input logic             set_flags,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags
);

  assert_neg_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flags[3] == $past(result[WIDTH-1])));

  assert_zero_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flags[2] == ($past(result) == '0)));

  assert_add_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel == 2'd0) |=> (flags[1] == ($past(result) < $past(op_a))));

  assert_sub_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel == 2'd2) |=> (flags[1] == ($past(op_a) >= $past(op_b))));

  assert_subc_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel == 2'd3 && op_a == op_b) |=> (flags[1] == $past(carry_in)));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags));

endmodule

bind addsub_flags_alu addsub_flags_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_sel    (op_sel),
  .carry_in  (carry_in),
  .set_flags (set_flags),
  .result    (result),
  .flags     (flags)
);

// File: tb/addsub_flags_alu_tb.sv
module addsub_flags_alu_tb;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [1:0]   op_sel;
  logic         carry_in;
  logic         set_flags;
  logic [W-1:0] result;
  logic [3:0]   flags;

  int errors = 0;
  int checks = 0;
  logic [3:0] exp_flags;

  addsub_flags_alu #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .carry_in(carry_in), .set_flags(set_flags), .result(result), .flags(flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string carry_req(input logic [1:0] op);
    case (op)
      2'd0: return "R4 carry add";
      2'd1: return "R5 carry add-with-carry";
      2'd2: return "R6 carry sub";
      default: return "R7 carry sub-with-carry";
    endcase
  endfunction

  // Applies one operation at the falling edge, checks the result at once and flags after the next rising edge
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] op,
                        input logic cin, input logic sf);
    logic [W:0]   wide;
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W-1:0] r;
    logic         v;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; carry_in = cin; set_flags = sf;
    b_eff = op[1] ? ~b : b;
    c_eff = op[0] ? cin : op[1];
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    r     = wide[W-1:0];
    v     = (a[W-1] == b_eff[W-1]) && (r[W-1] != a[W-1]);
    #1;
    check("R1 result", result, r);
    if (sf) exp_flags = {r[W-1], (r == '0), wide[W], v};
    @(posedge clk);
    @(negedge clk);
    set_flags = 1'b0;
    if (sf) begin
      check("R2 negative", {31'd0, flags[3]}, {31'd0, exp_flags[3]});
      check("R3 zero", {31'd0, flags[2]}, {31'd0, exp_flags[2]});
      check(carry_req(op), {31'd0, flags[1]}, {31'd0, exp_flags[1]});
      check(op[1] ? "R9 overflow sub" : "R8 overflow add", {31'd0, flags[0]}, {31'd0, exp_flags[0]});
    end else begin
      check("R10 hold", {28'd0, flags}, {28'd0, exp_flags});
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; op_sel = 2'd0; carry_in = 1'b0; set_flags = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset flags", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    exp_flags = 4'b0000;
  endtask

  task automatic test_corners;
    logic [W-1:0] vals [4];
    vals[0] = 32'h0000_0000; vals[1] = 32'h7FFF_FFFF;
    vals[2] = 32'h8000_0000; vals[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int op = 0; op < 4; op++)
          for (int c = 0; c < 2; c++)
            run_op(vals[i], vals[j], op[1:0], c[0], 1'b1);
  endtask

  task automatic test_equal_ties;
    run_op(32'h1234_5678, 32'hFFFF_FFFF, 2'd1, 1'b1, 1'b1); // R5 result equals A, carry 1
    run_op(32'h1234_5678, 32'h0000_0000, 2'd1, 1'b0, 1'b1); // R5 result equals A, carry 0
    run_op(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd3, 1'b1, 1'b1); // R7 equal, carry 1
    run_op(32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd3, 1'b0, 1'b1); // R7 equal, carry 0
    run_op(32'h0000_0005, 32'h0000_0005, 2'd2, 1'b0, 1'b1); // R6 equal gives carry
  endtask

  task automatic test_hold;
    run_op(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b0, 1'b1); // sets Z C V
    run_op(32'h0000_0001, 32'h0000_0001, 2'd0, 1'b0, 1'b0); // R10 flags unchanged
    run_op(32'hFFFF_FFFF, 32'h0000_0000, 2'd2, 1'b1, 1'b0); // R10 flags unchanged
  endtask

  task automatic test_random;
    for (int k = 0; k < 400; k++)
      run_op($urandom, $urandom, 2'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    test_reset;
    test_corners;
    test_equal_ties;
    test_hold;
    test_random;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule